// File: doc/BRIEF.md
# Indirect BIST Register Access Unit

This block sits behind a simple host register port. It lets the host reach a bank of eight internal self-test registers through only two host-visible locations. Four of the internal registers are pattern generators: 32-bit Galois LFSRs that drive stimulus into the logic under test. The other four are signature compactors: 32-bit MISRs that fold the test responses into a signature. The host first writes a configuration word that names the target. It then writes or reads a data location, and the block routes that access to the named internal register.

The configuration word also carries the timing and length settings for a downstream shift sequencer. A 2-bit speed code becomes a gap, counted in 8 ns base ticks, between the two non-overlapping shift clock pulses. A 12-bit field gives the scan chain length. Both appear on dedicated outputs. While self-test runs, a step strobe advances every generator and makes every compactor absorb its response word. A host load always takes priority over stepping.

Top module: `bist_access_unit`

## Requirements
- R1: After reset the configuration word reads 0x00000000, so target code 0 (generator 0) is selected. Every generator holds 0xFFFFFFFF, every compactor holds 0x00000000, and `shift_ticks` is 1.
- R2: The target code is configuration bits [30:28] (LSB-0 numbering). Codes 0 to 3 select generators 0 to 3 and codes 4 to 7 select compactors 0 to 3. A host write to the data location (0x0C) loads `req_wdata` into the selected register only, and is visible from the next cycle.
- R3: A host read of the data location returns the selected register on `rsp_rdata`, with `rsp_valid` high, one cycle after the request. The value returned is the register as it stood in the request cycle, which includes any load made in the cycle before. `rsp_valid` is low in every cycle that does not follow a read.
- R4: The configuration location (0x08) keeps only bits [30:28], [25:24] and [11:0] (mask 0x73000FFF). Writes to every other bit are dropped, and those bits read back as zero.
- R5: `shift_ticks` equals the speed code in configuration bits [25:24] plus one. Codes 0, 1, 2 and 3 give 1, 2, 3 and 4 base ticks of 8 ns.
- R6: `chain_len` equals configuration bits [11:0].
- R7: When `bist_run` and `bist_step` are both high, each generator s moves to (s >> 1) XOR (s[0] ? TAPS : 0), with TAPS = 0x80200003 by default. Generator k appears on `pattern_out[32k+31:32k]`.
- R8: When `bist_run` and `bist_step` are both high, compactor k moves to its generator-style step XOR `resp_in[32k+31:32k]`.
- R9: A data write in a cycle that also steps gives the targeted register exactly the written value. All other registers still step.
- R10: A write to any address other than 0x08 or 0x0C changes no state. A read of such an address returns 0 with `rsp_valid` high.
- R11: When `bist_run` is low or `bist_step` is low, every generator and compactor holds unless it is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Host register address |
| req_wdata | input | 32 | Host write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | 32 | Read data |
| bist_run | input | 1 | Self-test running |
| bist_step | input | 1 | Step strobe for generators and compactors |
| resp_in | input | 128 | Response words, one 32-bit slice per compactor |
| pattern_out | output | 128 | Generator states, one 32-bit slice per generator |
| shift_ticks | output | 3 | Shift pulse gap in 8 ns base ticks (1 to 4) |
| chain_len | output | 12 | Scan chain length |

## Verification
The assertions check on every cycle that:
- at most one internal register is loaded;
- a data write lands exactly in the register it targets, even against a simultaneous step;
- read responses appear exactly one cycle after a read request;
- the reserved configuration bits read back as zero;
- the tick output follows the written speed code;
- idle cycles leave the patterns unchanged.

The LFSR and MISR arithmetic, the mapping from code to register, and the silence of unused addresses are shown only by the bench. Its scenarios compare read-back values against its own model, both after directed corner cases and after long random mixes of loads, reads and steps.

// File: rtl/bist_acc_pkg.sv
package bist_acc_pkg;
  localparam int WORD_W  = 32;
  localparam int NUM_GEN = 4;
  localparam int NUM_SIG = 4;
  localparam int NUM_REG = NUM_GEN + NUM_SIG;
  localparam int SEL_W   = $clog2(NUM_REG);
  localparam int SPD_W   = 2;
  localparam int LEN_W   = 12;
  localparam int TICK_W  = SPD_W + 1;

  // field positions, LSB-0 numbering inside the 32-bit configuration word
  localparam int SEL_LSB = 28;
  localparam int SPD_LSB = 24;
  localparam int LEN_LSB = 0;

  localparam logic [WORD_W-1:0] CFG_MASK =
    (((WORD_W'(1) << SEL_W) - 1) << SEL_LSB) |
    (((WORD_W'(1) << SPD_W) - 1) << SPD_LSB) |
    (((WORD_W'(1) << LEN_W) - 1) << LEN_LSB);

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [SPD_W-1:0] spd;
    logic [LEN_W-1:0] len;
  } cfg_t;

  function automatic logic [WORD_W-1:0] galois_step(input logic [WORD_W-1:0] s,
                                                    input logic [WORD_W-1:0] taps);
    return (s >> 1) ^ (s[0] ? taps : '0);
  endfunction

  function automatic logic [WORD_W-1:0] misr_step(input logic [WORD_W-1:0] s,
                                                  input logic [WORD_W-1:0] taps,
                                                  input logic [WORD_W-1:0] resp);
    return galois_step(s, taps) ^ resp;
  endfunction

  function automatic cfg_t cfg_unpack(input logic [WORD_W-1:0] w);
    cfg_t c;
    c.sel = w[SEL_LSB +: SEL_W];
    c.spd = w[SPD_LSB +: SPD_W];
    c.len = w[LEN_LSB +: LEN_W];
    return c;
  endfunction

  function automatic logic [TICK_W-1:0] speed_to_ticks(input logic [SPD_W-1:0] code);
    return TICK_W'(code) + TICK_W'(1);
  endfunction
endpackage

// File: rtl/bist_cfg_reg.sv
module bist_cfg_reg
  import bist_acc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] cfg_word,
  output cfg_t              cfg,
  output logic [TICK_W-1:0] ticks
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word_q <= '0;
    else if (wr_en) word_q <= wr_data & CFG_MASK;
  end

  assign cfg_word = word_q;
  assign cfg      = cfg_unpack(word_q);
  assign ticks    = speed_to_ticks(cfg.spd);
endmodule

// File: rtl/bist_reg_bank.sv
module bist_reg_bank
  import bist_acc_pkg::*;
#(
  parameter int                N       = 4,
  parameter bit                IS_SIG  = 1'b0,
  parameter logic [WORD_W-1:0] TAPS    = 32'h8020_0003,
  parameter logic [WORD_W-1:0] RST_VAL = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        load_vec,
  input  logic [WORD_W-1:0]   load_data,
  input  logic                step_fire,
  input  logic [N*WORD_W-1:0] resp_flat,
  output logic [N*WORD_W-1:0] state_flat
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    logic [WORD_W-1:0] q;
    logic [WORD_W-1:0] nxt;
    logic [WORD_W-1:0] resp_w;

    if (IS_SIG) begin : g_sig
      assign resp_w = resp_flat[i*WORD_W +: WORD_W];
      assign nxt    = misr_step(q, TAPS, resp_w);
    end else begin : g_gen
      assign resp_w = resp_flat[i*WORD_W +: WORD_W] & '0;
      assign nxt    = galois_step(q, TAPS) ^ resp_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           q <= RST_VAL;
      else if (load_vec[i]) q <= load_data;
      else if (step_fire)   q <= nxt;
    end

    assign state_flat[i*WORD_W +: WORD_W] = q;
  end
endmodule

// File: rtl/bist_access_unit.sv
module bist_access_unit
  import bist_acc_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 8'h08,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h0C,
  parameter logic [WORD_W-1:0] LFSR_TAPS = 32'h8020_0003,
  parameter logic [WORD_W-1:0] GEN_SEED  = 32'hFFFF_FFFF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [WORD_W-1:0]         req_wdata,
  output logic                      rsp_valid,
  output logic [WORD_W-1:0]         rsp_rdata,
  input  logic                      bist_run,
  input  logic                      bist_step,
  input  logic [NUM_SIG*WORD_W-1:0] resp_in,
  output logic [NUM_GEN*WORD_W-1:0] pattern_out,
  output logic [TICK_W-1:0]         shift_ticks,
  output logic [LEN_W-1:0]          chain_len
);
  // named internal events
  logic              cfg_wr, cfg_rd, data_wr, data_rd, any_rd, step_fire;
  logic [SEL_W-1:0]  sel_code;
  logic [NUM_REG-1:0] load_vec;
  logic [WORD_W-1:0] cfg_word, sel_value, rd_mux;
  cfg_t              cfg;
  logic [NUM_GEN*WORD_W-1:0] gen_state;
  logic [NUM_SIG*WORD_W-1:0] sig_state;

  assign any_rd    = req_valid && !req_write;
  assign cfg_wr    = req_valid &&  req_write && (req_addr == CFG_ADDR);
  assign cfg_rd    = any_rd && (req_addr == CFG_ADDR);
  assign data_wr   = req_valid &&  req_write && (req_addr == DATA_ADDR);
  assign data_rd   = any_rd && (req_addr == DATA_ADDR);
  assign step_fire = bist_run && bist_step;

  bist_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr),
    .wr_data  (req_wdata),
    .cfg_word (cfg_word),
    .cfg      (cfg),
    .ticks    (shift_ticks)
  );

  assign sel_code  = cfg.sel;
  assign chain_len = cfg.len;

  for (genvar k = 0; k < NUM_REG; k++) begin : g_dec
    assign load_vec[k] = data_wr && (sel_code == SEL_W'(k));
  end

  bist_reg_bank #(
    .N(NUM_GEN), .IS_SIG(1'b0), .TAPS(LFSR_TAPS), .RST_VAL(GEN_SEED)
  ) u_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_vec   (load_vec[NUM_GEN-1:0]),
    .load_data  (req_wdata),
    .step_fire  (step_fire),
    .resp_flat  ({(NUM_GEN*WORD_W){1'b0}}),
    .state_flat (gen_state)
  );

  bist_reg_bank #(
    .N(NUM_SIG), .IS_SIG(1'b1), .TAPS(LFSR_TAPS), .RST_VAL('0)
  ) u_sig (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_vec   (load_vec[NUM_REG-1:NUM_GEN]),
    .load_data  (req_wdata),
    .step_fire  (step_fire),
    .resp_flat  (resp_in),
    .state_flat (sig_state)
  );

  assign pattern_out = gen_state;

  always_comb begin
    sel_value = '0;
    for (int k = 0; k < NUM_GEN; k++)
      if (sel_code == SEL_W'(k)) sel_value = gen_state[k*WORD_W +: WORD_W];
    for (int k = 0; k < NUM_SIG; k++)
      if (sel_code == SEL_W'(NUM_GEN + k)) sel_value = sig_state[k*WORD_W +: WORD_W];
  end

  always_comb begin
    if (cfg_rd)       rd_mux = cfg_word;
    else if (data_rd) rd_mux = sel_value;
    else              rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= any_rd;
      if (any_rd) rsp_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/bist_access_chk.sv
module bist_access_chk
  import bist_acc_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_write,
  input logic [WORD_W-1:0]         req_wdata,
  input logic                      rsp_valid,
  input logic [WORD_W-1:0]         rsp_rdata,
  input logic                      bist_run,
  input logic                      data_wr,
  input logic                      cfg_wr,
  input logic                      cfg_rd,
  input logic [SEL_W-1:0]          sel_code,
  input logic [NUM_REG-1:0]        load_vec,
  input logic [NUM_GEN*WORD_W-1:0] gen_state,
  input logic [NUM_SIG*WORD_W-1:0] sig_state,
  input logic [NUM_GEN*WORD_W-1:0] pattern_out,
  input logic [TICK_W-1:0]         shift_ticks
);
  logic              last_wr_q, last_cfg_rd_q;
  logic [SEL_W-1:0]  last_sel_q;
  logic [WORD_W-1:0] last_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_wr_q     <= 1'b0;
      last_cfg_rd_q <= 1'b0;
      last_sel_q    <= '0;
      last_data_q   <= '0;
    end else begin
      last_wr_q     <= data_wr;
      last_cfg_rd_q <= cfg_rd;
      last_sel_q    <= sel_code;
      last_data_q   <= req_wdata;
    end
  end

  function automatic logic [WORD_W-1:0] pick(input logic [SEL_W-1:0] s,
                                             input logic [NUM_GEN*WORD_W-1:0] g,
                                             input logic [NUM_SIG*WORD_W-1:0] m);
    logic [WORD_W-1:0] r;
    r = '0;
    for (int k = 0; k < NUM_GEN; k++) if (s == SEL_W'(k)) r = g[k*WORD_W +: WORD_W];
    for (int k = 0; k < NUM_SIG; k++) if (s == SEL_W'(NUM_GEN + k)) r = m[k*WORD_W +: WORD_W];
    return r;
  endfunction

  assert_load_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_vec));

  // R9: the written value lands even when a step fires in the same cycle
  assert_load_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last_wr_q |-> (pick(last_sel_q, gen_state, sig_state) == last_data_q));

  assert_rsp_follows_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  assert_no_spurious_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && last_cfg_rd_q) |-> ((rsp_rdata & ~CFG_MASK) == '0));

  assert_ticks_follow_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (shift_ticks == TICK_W'($past(req_wdata[SPD_LSB +: SPD_W])) + TICK_W'(1)));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!bist_run && !data_wr) |=> $stable(pattern_out));
endmodule

bind bist_access_unit bist_access_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_wdata   (req_wdata),
  .rsp_valid   (rsp_valid),
  .rsp_rdata   (rsp_rdata),
  .bist_run    (bist_run),
  .data_wr     (data_wr),
  .cfg_wr      (cfg_wr),
  .cfg_rd      (cfg_rd),
  .sel_code    (sel_code),
  .load_vec    (load_vec),
  .gen_state   (gen_state),
  .sig_state   (sig_state),
  .pattern_out (pattern_out),
  .shift_ticks (shift_ticks)
);

// File: tb/tb_bist_access_unit.sv
module tb_bist_access_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TAPS = 32'h8020_0003;
  localparam logic [7:0]  A_CFG = 8'h08, A_DATA = 8'h0C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic bist_run = 0, bist_step = 0;
  logic [127:0] resp_in = '0;
  logic [127:0] pattern_out;
  logic [2:0] shift_ticks;
  logic [11:0] chain_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  bist_access_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .bist_run(bist_run), .bist_step(bist_step),
    .resp_in(resp_in), .pattern_out(pattern_out), .shift_ticks(shift_ticks),
    .chain_len(chain_len)
  );

  int n_cmp = 0, n_bad = 0;
  logic [31:0] m_cfg;
  logic [31:0] m_reg [8];   // 0..3 generators, 4..7 compactors

  function automatic logic [31:0] ref_shift(input logic [31:0] s);
    logic [31:0] r;
    r = {1'b0, s[31:1]};
    if (s[0]) r = r ^ TAPS;
    return r;
  endfunction

  function automatic logic [31:0] ref_keep(input logic [31:0] w);
    return {1'b0, w[30:28], 2'b00, w[25:24], 12'h000, w[11:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_pattern();
    return {m_reg[3], m_reg[2], m_reg[1], m_reg[0]};
  endfunction

  // one clock: drive at negedge, update model at posedge, check at next negedge
  task automatic cyc(input bit v, input bit w, input logic [7:0] a, input logic [31:0] d,
                     input bit run, input bit stp, input logic [127:0] rsp, input string tag);
    logic [31:0] exp_rd;
    bit was_rd;
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    bist_run = run; bist_step = stp; resp_in = rsp;
    @(posedge clk);
    was_rd = v && !w;
    if (a == A_CFG) exp_rd = m_cfg;
    else if (a == A_DATA) exp_rd = m_reg[m_cfg[30:28]];
    else exp_rd = 32'h0;
    begin
      logic [31:0] nx [8];
      for (int k = 0; k < 8; k++) begin
        nx[k] = m_reg[k];
        if (run && stp) nx[k] = (k < 4) ? ref_shift(m_reg[k])
                                        : ref_shift(m_reg[k]) ^ rsp[(k-4)*32 +: 32];
      end
      if (v && w && a == A_DATA) nx[m_cfg[30:28]] = d;
      for (int k = 0; k < 8; k++) m_reg[k] = nx[k];
    end
    if (v && w && a == A_CFG) m_cfg = ref_keep(d);
    @(negedge clk);
    check(rsp_valid == was_rd, {tag, " R3 rsp_valid"}, 128'(rsp_valid), 128'(was_rd));
    if (was_rd) check(rsp_rdata == exp_rd, {tag, " R3 rdata"}, 128'(rsp_rdata), 128'(exp_rd));
    check(pattern_out == exp_pattern(), {tag, " R7 pattern"}, pattern_out, exp_pattern());
    check(shift_ticks == 3'(m_cfg[25:24]) + 3'd1, {tag, " R5 ticks"},
          128'(shift_ticks), 128'(m_cfg[25:24] + 1));
    check(chain_len == m_cfg[11:0], {tag, " R6 len"}, 128'(chain_len), 128'(m_cfg[11:0]));
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 8'h00, 0, 0, 0, '0, tag);
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    cyc(1, 1, a, d, 0, 0, '0, tag);
  endtask
  task automatic rd(input logic [7:0] a, input string tag);
    cyc(1, 0, a, 0, 0, 0, '0, tag);
  endtask
  task automatic sel(input int code, input logic [31:0] keep, input string tag);
    wr(A_CFG, (keep & ~32'h7000_0000) | (32'(code) << 28), tag);
  endtask

  bit done = 0;
  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    m_cfg = 0;
    for (int k = 0; k < 8; k++) m_reg[k] = (k < 4) ? 32'hFFFF_FFFF : 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    rd(A_CFG, "R1 cfg reset");
    for (int k = 0; k < 8; k++) begin
      sel(k, 0, "R1 sel");
      rd(A_DATA, "R1 reg reset");
    end
    sel(0, 0, "R1 back to 0");
    // R4, R5, R6: reserved bits masked
    wr(A_CFG, 32'hFFFF_FFFF, "R4 all ones");
    rd(A_CFG, "R4 readback");
    check(rsp_rdata == 32'h7300_0FFF, "R4 mask", 128'(rsp_rdata), 128'h7300_0FFF);
    for (int c = 0; c < 4; c++) begin
      wr(A_CFG, 32'(c) << 24 | 32'h0000_0ABC, "R5 code");
      check(shift_ticks == 3'(c + 1), "R5 tick table", 128'(shift_ticks), 128'(c + 1));
      check(chain_len == 12'hABC, "R6 length", 128'(chain_len), 128'hABC);
    end
    // R2: load every register and read back each
    for (int k = 0; k < 8; k++) begin
      sel(k, 32'h0100_0123, "R2 sel");
      wr(A_DATA, 32'hA500_0000 | 32'(k), "R2 load");
      rd(A_DATA, "R2 read");
      check(rsp_rdata == (32'hA500_0000 | 32'(k)), "R2 target", 128'(rsp_rdata),
            128'(32'hA500_0000 | 32'(k)));
    end
    // R3: read right after load returns new value
    sel(6, 0, "R3 sel");
    wr(A_DATA, 32'h1234_5678, "R3 load");
    rd(A_DATA, "R3 back to back");
    // R10: other addresses
    wr(8'h10, 32'hFFFF_FFFF, "R10 stray write");
    wr(8'h04, 32'h0, "R10 stray write2");
    rd(8'h10, "R10 stray read");
    check(rsp_rdata == 0, "R10 zero read", 128'(rsp_rdata), 0);
    rd(A_CFG, "R10 cfg intact");
    rd(A_DATA, "R10 data intact");
    // R11: strobe without run, run without strobe
    cyc(0, 0, 0, 0, 0, 1, {4{32'hDEAD_BEEF}}, "R11 step no run");
    cyc(0, 0, 0, 0, 1, 0, {4{32'hDEAD_BEEF}}, "R11 run no step");
    for (int k = 0; k < 8; k++) begin sel(k, 0, "R11 sel"); rd(A_DATA, "R11 hold"); end
    // R7, R8: stepping, zero seed corner for compactor
    sel(4, 0, "R8 sel");
    wr(A_DATA, 32'h0, "R8 zero");
    for (int i = 0; i < 6; i++)
      cyc(0, 0, 0, 0, 1, 1, {32'h1, 32'h8000_0001, 32'hFFFF_FFFF, 32'h0F0F_0F0F}, "R7 R8 step");
    for (int k = 0; k < 8; k++) begin sel(k, 0, "R8 sel"); rd(A_DATA, "R8 read sig"); end
    // R9: load during step
    sel(1, 0, "R9 sel");
    cyc(1, 1, A_DATA, 32'hCAFE_F00D, 1, 1, {4{32'h5555_AAAA}}, "R9 load vs step");
    rd(A_DATA, "R9 load won");
    sel(7, 0, "R9 sel sig");
    cyc(1, 1, A_DATA, 32'h0BAD_0BAD, 1, 1, {4{32'h3333_CCCC}}, "R9 load vs compact");
    rd(A_DATA, "R9 sig load won");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic [7:0] a;
      r = int'($urandom_range(0, 9));
      a = (r < 4) ? A_DATA : (r < 7) ? A_CFG : 8'($urandom_range(0, 31));
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, a,
          (r < 6) ? $urandom : (32'($urandom_range(0, 7)) << 28 | 32'($urandom_range(0, 4095))),
          $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
          {$urandom, $urandom, $urandom, $urandom}, "rand R2 R7 R8 R9 R10");
    end
    idle("end");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule